// File: doc/BRIEF.md
# Three-Channel Selectable Threshold Trigger

This block produces one trigger line for each of three parallel 8-bit sample streams. The three streams come from converters that cover different signal ranges. Each line feeds a differential output driver. A configuration word for each channel picks what drives that line. The choices are a fast external comparator bit, a per-sample test against a programmable digital threshold, or the sum over a sliding window of the latest 8, 16 or 32 accepted samples tested against the same threshold. A fourth code switches the channel off.

The windowed sum is kept incrementally. A 32-entry history per channel lets the newest sample be added and the sample leaving the window be subtracted in the same cycle. A small state machine per channel, with states `WS_FILL` and `WS_ARMED`, tracks whether the window has been filled. It takes `fill_done` (FILL to ARMED, after N accepted samples) and `win_reset` (ARMED to FILL, or FILL to FILL, on a window-length change). Configuration is written through a single-cycle strobe with an address and data. All trigger outputs are registered.

Top module: `trig_multi_chan`

## Requirements
- R1: The three trigger outputs are independent. Each uses only its own sample lane (`smp_i[8c+7:8c]`), its own comparator bit `cmp_i[c]` and its own configuration.
- R2: After reset every channel is in the disabled mode, and all trigger outputs are low.
- R3: Mode code 00 (comparator) drives `trig_o[c]` with the value `cmp_i[c]` had at the previous rising clock edge.
- R4: Mode code 01 (level) sets `trig_o[c]` after an edge where `smp_vld` is high and the sample is strictly greater than the threshold. Otherwise the output is low, including when the sample equals the threshold or `smp_vld` is low.
- R5: Mode code 10 (window) sets `trig_o[c]` one cycle after the window sum is updated, when the sum of the latest N accepted samples is strictly greater than the threshold. The sample that leaves the window is removed from the sum.
- R6: Window code 00 selects N=8, 01 selects N=16, and both 10 and 11 select N=32.
- R7: In window mode, the output stays low until N samples have been accepted since reset or since the last window-length change.
- R8: A configuration write whose window code differs from the stored one clears that channel's history and sum, and refills the window. A write with the same window code leaves the sum and the filled state intact.
- R9: Mode code 11 forces the channel's trigger low, whatever the inputs are.
- R10: A write with `cfg_we` high updates channel `cfg_addr` from the next edge onward. The data layout is `cfg_wdata[1:0]` mode, `[3:2]` window code and `[16:4]` threshold. Addresses 3 and above are ignored.
- R11: A sample is accepted only on an edge where `smp_vld` is high. While `smp_vld` is low the window sums do not change.
- R12: The window sum holds 32 samples of 255 (8160) without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Samples on all lanes are valid this cycle |
| smp_i | input | 24 | Three 8-bit sample lanes, lane c at bits [8c+7:8c] |
| cmp_i | input | 3 | External fast comparator result per channel |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Channel index of the write |
| cfg_wdata | input | 17 | Threshold, window code and mode |
| trig_o | output | 3 | Registered trigger line per channel |

## Verification
The bench probes the equal-to-threshold boundary in both digital modes. A design that compares with greater-or-equal would fire there. It counts samples up to N-1 and then N after every window change. A design that arms early, or that forgets to clear on a length change, shows a stale trigger. It slides a single large sample through an 8-wide window to catch a wrong tail index, which would leave the sum high for too long. It fills a 32-wide window with full-scale samples to expose a narrow accumulator. It also rewrites a channel with an unchanged window code. A design that clears on every write would drop an armed trigger there.

// File: rtl/trig_pkg.sv
package trig_pkg;

    typedef enum logic [1:0] {
        MODE_CMP   = 2'b00,
        MODE_LEVEL = 2'b01,
        MODE_SUM   = 2'b10,
        MODE_OFF   = 2'b11
    } trig_mode_e;

    typedef enum logic [1:0] {
        WIN_SHORT = 2'b00,
        WIN_MID   = 2'b01,
        WIN_LONG  = 2'b10,
        WIN_RSVD  = 2'b11
    } win_code_e;

    typedef enum logic {
        WS_FILL  = 1'b0,
        WS_ARMED = 1'b1
    } win_state_e;

endpackage

// File: rtl/trig_cfg_regs.sv
module trig_cfg_regs
    import trig_pkg::*;
#(
    parameter int NCH   = 3,
    parameter int THR_W = 13,
    parameter int AW    = 2,
    parameter int DW    = THR_W + 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [AW-1:0]               addr,
    input  logic [DW-1:0]               wdata,
    output trig_mode_e [NCH-1:0]        mode_o,
    output win_code_e  [NCH-1:0]        win_o,
    output logic [NCH-1:0][THR_W-1:0]   thr_o,
    output logic [NCH-1:0]              clr_o
);

    trig_mode_e               new_mode;
    win_code_e                new_win;
    logic [THR_W-1:0]         new_thr;

    assign new_mode = trig_mode_e'(wdata[1:0]);
    assign new_win  = win_code_e'(wdata[3:2]);
    assign new_thr  = wdata[DW-1:4];

    for (genvar c = 0; c < NCH; c++) begin : g_reg
        logic hit;
        assign hit = we && (addr == AW'(c));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mode_o[c] <= MODE_OFF;
                win_o[c]  <= WIN_SHORT;
                thr_o[c]  <= '1;
            end else if (hit) begin
                mode_o[c] <= new_mode;
                win_o[c]  <= new_win;
                thr_o[c]  <= new_thr;
            end
        end

        // a changed window length restarts the window in the same edge
        assign clr_o[c] = hit && (new_win != win_o[c]);
    end

endmodule

// File: rtl/trig_window_sum.sv
module trig_window_sum
    import trig_pkg::*;
#(
    parameter int SW    = 8,
    parameter int MAXW  = 32,
    parameter int ACC_W = SW + $clog2(MAXW)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             vld,
    input  logic [SW-1:0]    smp,
    input  win_code_e        win,
    output logic [ACC_W-1:0] sum_o,
    output logic             armed_o
);

    localparam int IDX_W = $clog2(MAXW);
    localparam int CNT_W = $clog2(MAXW + 1);

    logic [SW-1:0]    hist_q [MAXW];
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] len;
    logic [IDX_W-1:0] tail_idx;
    logic [SW-1:0]    leaving;
    win_state_e       state_q, state_d;
    logic             fill_done;
    logic             win_reset;

    function automatic logic [CNT_W-1:0] win_len(input win_code_e code);
        case (code)
            WIN_SHORT: win_len = CNT_W'(MAXW / 4);
            WIN_MID:   win_len = CNT_W'(MAXW / 2);
            default:   win_len = CNT_W'(MAXW);
        endcase
    endfunction

    assign len       = win_len(win);
    assign tail_idx  = IDX_W'(len - CNT_W'(1));
    assign leaving   = hist_q[tail_idx];
    assign win_reset = clr;
    assign fill_done = vld && (cnt_q == len - CNT_W'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WS_FILL;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WS_FILL:  if (win_reset)      state_d = WS_FILL;
                      else if (fill_done) state_d = WS_ARMED;
            WS_ARMED: if (win_reset)      state_d = WS_FILL;
        endcase
    end

    // outputs
    always_comb begin
        armed_o = 1'b0;
        unique case (state_q)
            WS_FILL:  armed_o = 1'b0;
            WS_ARMED: armed_o = 1'b1;
        endcase
    end

    // fill counter, only advances while filling
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         cnt_q <= '0;
        else if (win_reset)                 cnt_q <= '0;
        else if (vld && state_q == WS_FILL) cnt_q <= cnt_q + CNT_W'(1);
    end

    // incremental running sum
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         sum_o <= '0;
        else if (win_reset) sum_o <= '0;
        else if (vld)       sum_o <= sum_o + ACC_W'(smp) - ACC_W'(leaving);
    end

    // history shift register, index 0 newest
    for (genvar i = 0; i < MAXW; i++) begin : g_hist
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         hist_q[i] <= '0;
            else if (win_reset) hist_q[i] <= '0;
            else if (vld)       hist_q[i] <= (i == 0) ? smp : hist_q[(i == 0) ? 0 : i - 1];
        end
    end

endmodule

// File: rtl/trig_channel.sv
module trig_channel
    import trig_pkg::*;
#(
    parameter int SW    = 8,
    parameter int ACC_W = 13,
    parameter int THR_W = ACC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  trig_mode_e       mode,
    input  logic [THR_W-1:0] thr,
    input  logic             vld,
    input  logic [SW-1:0]    smp,
    input  logic             cmp,
    input  logic [ACC_W-1:0] sum,
    input  logic             armed,
    output logic             trig_o
);

    logic hit;

    always_comb begin
        hit = 1'b0;
        unique case (mode)
            MODE_CMP:   hit = cmp;
            MODE_LEVEL: hit = vld && (THR_W'(smp) > thr);
            MODE_SUM:   hit = armed && (THR_W'(sum) > thr);
            MODE_OFF:   hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trig_o <= 1'b0;
        else        trig_o <= hit;
    end

endmodule

// File: rtl/trig_multi_chan.sv
module trig_multi_chan
    import trig_pkg::*;
#(
    parameter int  NCH   = 3,
    parameter int  SW    = 8,
    parameter int  MAXW  = 32,
    localparam int ACC_W = SW + $clog2(MAXW),
    localparam int THR_W = ACC_W,
    localparam int AW    = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int DW    = THR_W + 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_vld,
    input  logic [NCH*SW-1:0] smp_i,
    input  logic [NCH-1:0]    cmp_i,
    input  logic              cfg_we,
    input  logic [AW-1:0]     cfg_addr,
    input  logic [DW-1:0]     cfg_wdata,
    output logic [NCH-1:0]    trig_o
);

    trig_mode_e [NCH-1:0]      mode_w;
    win_code_e  [NCH-1:0]      win_w;
    logic [NCH-1:0][THR_W-1:0] thr_w;
    logic [NCH-1:0][ACC_W-1:0] sum_w;
    logic [NCH-1:0]            armed_w;
    logic [NCH-1:0]            clr_w;

    trig_cfg_regs #(
        .NCH(NCH), .THR_W(THR_W), .AW(AW), .DW(DW)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .mode_o(mode_w), .win_o(win_w), .thr_o(thr_w), .clr_o(clr_w)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        trig_window_sum #(
            .SW(SW), .MAXW(MAXW), .ACC_W(ACC_W)
        ) u_win (
            .clk(clk), .rst_n(rst_n), .clr(clr_w[c]), .vld(smp_vld),
            .smp(smp_i[c*SW +: SW]), .win(win_w[c]),
            .sum_o(sum_w[c]), .armed_o(armed_w[c])
        );

        trig_channel #(
            .SW(SW), .ACC_W(ACC_W), .THR_W(THR_W)
        ) u_trig (
            .clk(clk), .rst_n(rst_n), .mode(mode_w[c]), .thr(thr_w[c]),
            .vld(smp_vld), .smp(smp_i[c*SW +: SW]), .cmp(cmp_i[c]),
            .sum(sum_w[c]), .armed(armed_w[c]), .trig_o(trig_o[c])
        );
    end

endmodule

// File: rtl/trig_multi_chan_chk.sv
module trig_multi_chan_chk
    import trig_pkg::*;
#(
    parameter int  NCH   = 3,
    parameter int  SW    = 8,
    parameter int  MAXW  = 32,
    localparam int ACC_W = SW + $clog2(MAXW),
    localparam int THR_W = ACC_W
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      smp_vld,
    input logic [NCH-1:0]            cmp_i,
    input logic [NCH-1:0]            trig_o,
    input trig_mode_e [NCH-1:0]      mode,
    input logic [NCH-1:0][ACC_W-1:0] sum,
    input logic [NCH-1:0]            armed,
    input logic [NCH-1:0]            clr
);

    localparam int MAX_SUM = MAXW * ((1 << SW) - 1);

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        // R9
        off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (mode[c] == MODE_OFF) |=> !trig_o[c]);

        // R3
        cmp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (mode[c] == MODE_CMP) |=> (trig_o[c] == $past(cmp_i[c])));

        // R4
        level_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (mode[c] == MODE_LEVEL && !smp_vld) |=> !trig_o[c]);

        // R7
        fill_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (mode[c] == MODE_SUM && !armed[c]) |=> !trig_o[c]);

        // R8
        clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
            clr[c] |=> (sum[c] == '0 && !armed[c]));

        // R11
        hold_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!smp_vld && !clr[c]) |=> $stable(sum[c]));

        // R12
        no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (sum[c] <= ACC_W'(MAX_SUM)));
    end

endmodule

bind trig_multi_chan trig_multi_chan_chk #(
    .NCH(NCH), .SW(SW), .MAXW(MAXW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .cmp_i(cmp_i), .trig_o(trig_o),
    .mode(mode_w), .sum(sum_w), .armed(armed_w), .clr(clr_w)
);

// File: tb/tb_trig_multi_chan.sv
module tb_trig_multi_chan;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_vld = 1'b0;
    logic [23:0] smp_i = '0;
    logic [2:0]  cmp_i = 3'b111;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [16:0] cfg_wdata = '0;
    logic [2:0]  trig_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    trig_multi_chan dut (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_i(smp_i), .cmp_i(cmp_i),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .trig_o(trig_o)
    );

    always #5 clk = ~clk;

    // level-mode vectors at threshold 100: {sample, expected trigger}
    localparam logic [8:0] LVL_VEC [8] = '{
        {8'd0,   1'b0}, {8'd99,  1'b0}, {8'd100, 1'b0}, {8'd101, 1'b1},
        {8'd255, 1'b1}, {8'd100, 1'b0}, {8'd200, 1'b1}, {8'd1,   1'b0}
    };

    task automatic chk(input int ch, input logic exp, input string req);
        total++;
        if (trig_o[ch] !== exp) begin
            bad++;
            $display("FAIL %s ch%0d trig actual=%b expected=%b", req, ch, trig_o[ch], exp);
        end
    endtask

    task automatic wr(input int ch, input logic [1:0] mode, input logic [1:0] win,
                      input logic [12:0] thr);
        cfg_we = 1'b1;
        cfg_addr = 2'(ch);
        cfg_wdata = {thr, win, mode};
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic push(input logic [7:0] s0, input logic [7:0] s1, input logic [7:0] s2);
        smp_vld = 1'b1;
        smp_i = {s2, s1, s0};
        @(posedge clk);
        @(negedge clk);
        smp_vld = 1'b0;
    endtask

    task automatic idle();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R2: reset state with comparator bits high
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle();
        idle();
        for (int c = 0; c < 3; c++) chk(c, 1'b0, "R2");

        // R3: comparator pass-through, registered
        wr(0, 2'b00, 2'b00, 13'd0);
        cmp_i = 3'b111;
        idle();
        chk(0, 1'b1, "R3");
        chk(1, 1'b0, "R9");
        cmp_i = 3'b110;
        idle();
        chk(0, 1'b0, "R3");

        // R4: level threshold table
        wr(0, 2'b01, 2'b00, 13'd100);
        for (int i = 0; i < 8; i++) begin
            push(LVL_VEC[i][8:1], 8'd0, 8'd0);
            chk(0, LVL_VEC[i][0], "R4");
        end
        smp_i = 24'd200;
        idle();
        chk(0, 1'b0, "R4");

        // R7 / R6: window 16 after a length change
        wr(0, 2'b10, 2'b01, 13'd0);
        for (int i = 0; i < 15; i++) push(8'd1, 8'd0, 8'd0);
        idle();
        chk(0, 1'b0, "R7");
        push(8'd1, 8'd0, 8'd0);
        idle();
        chk(0, 1'b1, "R6");

        // R5: window 8 boundary and slide-out
        wr(0, 2'b10, 2'b00, 13'd80);
        for (int i = 0; i < 8; i++) push(8'd10, 8'd0, 8'd0);
        idle();
        chk(0, 1'b0, "R5");
        push(8'd20, 8'd0, 8'd0);
        idle();
        chk(0, 1'b1, "R5");
        for (int i = 0; i < 7; i++) push(8'd10, 8'd0, 8'd0);
        idle();
        chk(0, 1'b1, "R5");
        push(8'd10, 8'd0, 8'd0);
        idle();
        chk(0, 1'b0, "R5");

        // R8: same window code keeps the sum of 80
        wr(0, 2'b01, 2'b00, 13'd80);
        wr(0, 2'b10, 2'b00, 13'd79);
        idle();
        chk(0, 1'b1, "R8");
        // R8: new window code clears
        wr(0, 2'b10, 2'b10, 13'd0);
        idle();
        chk(0, 1'b0, "R8");

        // R12: full-scale 32-sample window
        for (int i = 0; i < 31; i++) push(8'd255, 8'd0, 8'd0);
        idle();
        chk(0, 1'b0, "R7");
        wr(0, 2'b10, 2'b10, 13'd8159);
        push(8'd255, 8'd0, 8'd0);
        idle();
        chk(0, 1'b1, "R12");
        wr(0, 2'b10, 2'b10, 13'd8160);
        idle();
        chk(0, 1'b0, "R12");

        // R11: samples without valid are not accepted
        smp_i = '0;
        repeat (3) idle();
        wr(0, 2'b10, 2'b10, 13'd8159);
        idle();
        chk(0, 1'b1, "R11");

        // R6: reserved window code behaves as 32
        wr(1, 2'b10, 2'b11, 13'd0);
        for (int i = 0; i < 31; i++) push(8'd0, 8'd1, 8'd0);
        idle();
        chk(1, 1'b0, "R6");
        push(8'd0, 8'd1, 8'd0);
        idle();
        chk(1, 1'b1, "R6");

        // R1: channel 2 level mode uses its own lane only
        wr(2, 2'b01, 2'b00, 13'd5);
        push(8'd0, 8'd0, 8'd9);
        chk(2, 1'b1, "R1");
        push(8'd9, 8'd9, 8'd0);
        chk(2, 1'b0, "R1");
        chk(1, 1'b1, "R1");

        // R9: disabled channel ignores everything
        wr(2, 2'b11, 2'b00, 13'd0);
        cmp_i = 3'b111;
        push(8'd255, 8'd255, 8'd255);
        idle();
        chk(2, 1'b0, "R9");

        // R10: out-of-range address is ignored
        wr(3, 2'b00, 2'b00, 13'd0);
        idle();
        chk(2, 1'b0, "R10");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule